// File: doc/BRIEF.md
# Embedded Sync Timing Decoder

This block takes a digital component video byte stream with embedded timing codes (4:2:2, eight bits per byte, one byte per clock) and rebuilds the discrete timing signals from it. It watches for the four-byte timing reference pattern made of FFh, 00h, 00h and a status byte. From the status byte it takes the field, vertical and horizontal flags, and from them it produces horizontal sync, blanking and field outputs. The byte stream passes through with a fixed delay, so that every regenerated signal lines up with the bytes it describes.

Inside the active part of each line the block tells which component each byte carries. After every start-of-active code it restarts that labelling, so the first active byte is always marked as the blue difference sample. It also checks the line structure for the selected standard. The active segment must hold exactly 1440 bytes. The blanking segment must hold 268 bytes on the 525-line standard and 280 bytes on the 625-line standard. Codes must alternate between end-of-active and start-of-active. Status bytes whose protection bits are wrong are reported.

Top module: `sdec_top`

## Requirements
- R1: While reset is held, data_o is 00h, hsync_o is 0, blank_o is 1, field_o is 0, act_o is 0, phase_o is 0, and both error outputs are 0.
- R2: data_o repeats din_i four clocks later. A byte applied before clock edge n appears on data_o after edge n+3.
- R3: A timing code is the input run FFh, 00h, 00h, XY. In XY, bit 6 is the field flag F, bit 5 is V, and bit 4 is H (1 = end of active video, 0 = start of active video). In the cycle where the code's FFh is on data_o, field_o takes F and blank_o takes V OR H. Both then hold until the next code.
- R4: hsync_o goes high in the cycle where the FFh of an end-of-active code is on data_o. It stays high for exactly 4 cycles.
- R5: act_o is high for every data_o byte that follows the four code bytes of a start-of-active code, up to the FFh of the next code. phase_o labels those bytes 0 (Cb), 1 (Y), 2 (Cr), 3 (Y), repeating from 0 at the first byte. Outside active bytes phase_o is 0.
- R6: prot_err_o pulses for the single cycle in which a code's FFh is on data_o when XY bit 7 is 0, or when XY bits 3..0 differ from {V^H, F^H, F^V, F^V^H}. The flags of that code are still applied.
- R7: len_err_o pulses with the FFh of an end-of-active code if the start-of-active code before it was not followed by exactly 1440 payload bytes.
- R8: len_err_o pulses with the FFh of a start-of-active code if the payload after the preceding end-of-active code was not 268 bytes (std_625_i = 0) or 280 bytes (std_625_i = 1).
- R9: len_err_o pulses with the FFh of a code of the same kind as the code before it. The first code after reset is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_625_i | input | 1 | 1 selects the 625-line blanking length, 0 the 525-line length |
| din_i | input | 8 | Incoming byte stream |
| data_o | output | 8 | Byte stream delayed by four clocks |
| hsync_o | output | 1 | Regenerated horizontal sync |
| blank_o | output | 1 | Regenerated blanking (V OR H) |
| field_o | output | 1 | Regenerated field flag |
| act_o | output | 1 | High on active payload bytes |
| phase_o | output | 2 | Component label of the active byte |
| prot_err_o | output | 1 | Protection-bit error pulse |
| len_err_o | output | 1 | Segment length or code-order error pulse |

## Verification
The bench first sends well-formed lines on both standards. It varies F and V so that field_o and blank_o are seen to follow each flag on its own. Lines one byte short in the active segment, or two bytes long in the blanking segment, tell a correct length check apart from an off-by-one count. A 268-byte blanking segment is also sent while the 625-line standard is selected, which separates the two blanking limits. Corrupted status bytes (a flipped protection bit, a cleared bit 7) and two end-of-active codes in a row exercise the error paths. A behavioural model predicts every output on every clock.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

    localparam logic [7:0] SDEC_SYNC_HI = 8'hFF;
    localparam logic [7:0] SDEC_SYNC_LO = 8'h00;

    // Expected protection nibble for a given F, V, H triple
    function automatic logic [3:0] sdec_prot(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/sdec_code_det.sv
module sdec_code_det
    import sdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din_i,
    output logic       hit_o,
    output logic [7:0] xy_o,
    output logic [7:0] data_o
);

    typedef struct packed {
        logic [7:0] h1;
        logic [7:0] h2;
        logic [7:0] h3;
        logic [7:0] dout;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.h1   = din_i;
        st_d.h2   = st_q.h1;
        st_d.h3   = st_q.h2;
        st_d.dout = st_q.h3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The status byte is on the input while the preamble sits in history
    assign hit_o  = (st_q.h3 == SDEC_SYNC_HI) && (st_q.h2 == SDEC_SYNC_LO) &&
                    (st_q.h1 == SDEC_SYNC_LO);
    assign xy_o   = din_i;
    assign data_o = st_q.dout;

endmodule

// File: rtl/sdec_line_track.sv
module sdec_line_track
    import sdec_pkg::*;
#(
    parameter int ACT_LEN = 1440,
    parameter int BLK_525 = 268,
    parameter int BLK_625 = 280,
    parameter int HS_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std_625_i,
    input  logic       hit_i,
    input  logic [7:0] xy_i,
    output logic       hsync_o,
    output logic       blank_o,
    output logic       field_o,
    output logic       act_o,
    output logic [1:0] phase_o,
    output logic       prot_err_o,
    output logic       len_err_o
);

    localparam int CODE_LEN = 4;
    localparam int MAX_SEG  = (ACT_LEN > BLK_625) ? ACT_LEN : BLK_625;
    localparam int CW       = $clog2(MAX_SEG + 2 * CODE_LEN);
    localparam int HW       = $clog2(HS_LEN + 1);
    localparam logic [CW-1:0] EXP_ACT = CW'(ACT_LEN + CODE_LEN - 1);
    localparam logic [CW-1:0] EXP_525 = CW'(BLK_525 + CODE_LEN - 1);
    localparam logic [CW-1:0] EXP_625 = CW'(BLK_625 + CODE_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] pos;
        logic          in_act;
        logic          have_ref;
        logic          last_eav;
        logic          field;
        logic          blank;
        logic [HW-1:0] hs_cnt;
        logic          perr;
        logic          lerr;
    } trk_st_t;

    trk_st_t       st_d, st_q;
    logic          is_eav;
    logic [CW-1:0] exp_len;

    always_comb begin
        st_d      = st_q;
        st_d.perr = 1'b0;
        st_d.lerr = 1'b0;
        is_eav    = xy_i[4];
        exp_len   = is_eav ? EXP_ACT : (std_625_i ? EXP_625 : EXP_525);
        if (st_q.hs_cnt != '0) begin
            st_d.hs_cnt = st_q.hs_cnt - 1'b1;
        end
        if (st_q.pos != '1) begin
            st_d.pos = st_q.pos + 1'b1;
        end
        if (hit_i) begin
            st_d.pos      = '0;
            st_d.in_act   = !is_eav;
            st_d.have_ref = 1'b1;
            st_d.last_eav = is_eav;
            st_d.field    = xy_i[6];
            st_d.blank    = xy_i[5] | xy_i[4];
            if (is_eav) begin
                st_d.hs_cnt = HW'(HS_LEN);
            end
            st_d.perr = !xy_i[7] || (xy_i[3:0] != sdec_prot(xy_i[6], xy_i[5], xy_i[4]));
            st_d.lerr = st_q.have_ref && ((st_q.last_eav == is_eav) || (st_q.pos != exp_len));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.blank    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_o    = (st_q.hs_cnt != '0);
    assign blank_o    = st_q.blank;
    assign field_o    = st_q.field;
    assign act_o      = st_q.in_act && (st_q.pos >= CW'(CODE_LEN));
    assign phase_o    = act_o ? st_q.pos[1:0] : 2'd0;
    assign prot_err_o = st_q.perr;
    assign len_err_o  = st_q.lerr;

    AST_EAV_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && xy_i[4] |=> hsync_o && blank_o); // R4
    AST_SAV_CODE_INACT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && !xy_i[4] |=> !act_o && (field_o == $past(xy_i[6]))); // R5
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        act_o && $past(act_o) |-> phase_o == $past(phase_o) + 2'd1); // R5
    AST_ERR_AT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err_o || prot_err_o) |-> $past(hit_i)); // R7
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit_i) |-> $stable(field_o) && $stable(blank_o)); // R3

endmodule

// File: rtl/sdec_top.sv
module sdec_top
    import sdec_pkg::*;
#(
    parameter int ACT_LEN = 1440,
    parameter int BLK_525 = 268,
    parameter int BLK_625 = 280,
    parameter int HS_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std_625_i,
    input  logic [7:0] din_i,
    output logic [7:0] data_o,
    output logic       hsync_o,
    output logic       blank_o,
    output logic       field_o,
    output logic       act_o,
    output logic [1:0] phase_o,
    output logic       prot_err_o,
    output logic       len_err_o
);

    logic       hit_w;
    logic [7:0] xy_w;

    sdec_code_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (din_i),
        .hit_o  (hit_w),
        .xy_o   (xy_w),
        .data_o (data_o)
    );

    sdec_line_track #(
        .ACT_LEN (ACT_LEN),
        .BLK_525 (BLK_525),
        .BLK_625 (BLK_625),
        .HS_LEN  (HS_LEN)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .std_625_i  (std_625_i),
        .hit_i      (hit_w),
        .xy_i       (xy_w),
        .hsync_o    (hsync_o),
        .blank_o    (blank_o),
        .field_o    (field_o),
        .act_o      (act_o),
        .phase_o    (phase_o),
        .prot_err_o (prot_err_o),
        .len_err_o  (len_err_o)
    );

endmodule

// File: tb/sdec_top_tb.sv
module sdec_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_625 = 1'b0;
    logic [7:0] din = 8'h10;
    logic [7:0] data_o;
    logic       hsync_o, blank_o, field_o, act_o, prot_err_o, len_err_o;
    logic [1:0] phase_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    sdec_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .std_625_i  (std_625),
        .din_i      (din),
        .data_o     (data_o),
        .hsync_o    (hsync_o),
        .blank_o    (blank_o),
        .field_o    (field_o),
        .act_o      (act_o),
        .phase_o    (phase_o),
        .prot_err_o (prot_err_o),
        .len_err_o  (len_err_o)
    );

    // Behavioural reference: input history as a queue, segment sizes as integers
    int m_hist[$];
    int m_data, m_field, m_blank, m_hs, m_perr, m_lerr;
    int m_opos, m_inact, m_seen, m_prev_eav, m_cnt;
    bit m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = {}; m_data = 0; m_field = 0; m_blank = 1; m_hs = 0;
            m_perr = 0; m_lerr = 0; m_opos = 0; m_inact = 0; m_seen = 0;
            m_prev_eav = 0; m_cnt = 0;
        end else begin
            int  xy, f, v, h, want;
            bit  code;
            code = (m_hist.size() >= 3) && (m_hist[m_hist.size()-3] == 255) &&
                   (m_hist[m_hist.size()-2] == 0) && (m_hist[m_hist.size()-1] == 0);
            m_data = (m_hist.size() >= 3) ? m_hist[m_hist.size()-3] : 0;
            m_hist.push_back(int'(din));
            if (m_hist.size() > 8) void'(m_hist.pop_front());
            m_perr = 0; m_lerr = 0;
            if (m_hs > 0) m_hs = m_hs - 1;
            m_opos = m_opos + 1;
            xy = int'(din);
            if (code) begin
                f = (xy >> 6) & 1; v = (xy >> 5) & 1; h = (xy >> 4) & 1;
                // m_cnt counts payload plus the three preamble bytes
                if (h == 1) want = 1440;
                else want = std_625 ? 280 : 268;
                if (m_seen && ((m_prev_eav == h) || (m_cnt - 3 != want))) m_lerr = 1;
                if (((xy >> 7) & 1) == 0) m_perr = 1;
                if ((xy & 15) != (((v ^ h) << 3) | ((f ^ h) << 2) | ((f ^ v) << 1) | (f ^ v ^ h)))
                    m_perr = 1;
                m_field = f; m_blank = v | h;
                if (h == 1) m_hs = 4;
                m_inact = (h == 0); m_seen = 1; m_prev_eav = h;
                m_opos = 0; m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        m_valid = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            int e_act, e_ph;
            e_act = (m_inact != 0) && (m_opos >= 4);
            e_ph  = e_act ? (m_opos - 4) % 4 : 0;
            if (!rst_n) begin
                chk("R1 data_o", int'(data_o), 0);
                chk("R1 hsync_o", int'(hsync_o), 0);
                chk("R1 blank_o", int'(blank_o), 1);
                chk("R1 field_o", int'(field_o), 0);
                chk("R1 act_o", int'(act_o), 0);
                chk("R1 phase_o", int'(phase_o), 0);
                chk("R1 errors", int'(prot_err_o) + int'(len_err_o), 0);
            end else begin
                chk("R2 data_o", int'(data_o), m_data);
                chk("R3 field_o", int'(field_o), m_field);
                chk("R3 blank_o", int'(blank_o), m_blank);
                chk("R4 hsync_o", int'(hsync_o), (m_hs > 0) ? 1 : 0);
                chk("R5 act_o", int'(act_o), e_act);
                chk("R5 phase_o", int'(phase_o), e_ph);
                chk("R6 prot_err_o", int'(prot_err_o), m_perr);
                chk("R7 R8 R9 len_err_o", int'(len_err_o), m_lerr);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        din = b;
    endtask

    // bad: 0 clean, 1 flip a protection bit, 2 clear bit 7
    task automatic code(input bit f, input bit v, input bit h, input int bad);
        logic [7:0] xy;
        xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        if (bad == 1) xy[0] = ~xy[0];
        if (bad == 2) xy[7] = 1'b0;
        send(8'hFF); send(8'h00); send(8'h00); send(xy);
    endtask

    task automatic line(input bit f, input bit v, input int nblk, input int nact, input int bad);
        code(f, v, 1'b1, bad);
        for (int i = 0; i < nblk; i++) send((i % 2) ? 8'h10 : 8'h80);
        code(f, v, 1'b0, 0);
        for (int i = 0; i < nact; i++) send(8'h20 + 8'(i % 160));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) send(8'h10);
        // R3 R4 R5: clean 525-line lines, flags varied
        line(0, 1, 268, 1440, 0);
        line(0, 0, 268, 1440, 0);
        line(1, 0, 268, 1440, 0);
        line(1, 1, 268, 1440, 0);
        // R7: active segment one byte short
        line(0, 0, 268, 1439, 0);
        line(0, 0, 268, 1440, 0);
        // R8: blanking two bytes long
        line(0, 0, 270, 1440, 0);
        // R6: corrupted status bytes
        line(0, 0, 268, 1440, 1);
        line(1, 0, 268, 1440, 2);
        // R9: two end-of-active codes in a row
        code(0, 0, 1'b1, 0);
        for (int i = 0; i < 20; i++) send(8'h80);
        line(0, 0, 268, 1440, 0);
        // R8: 625-line standard, correct then 525 length
        std_625 = 1'b1;
        line(0, 0, 280, 1440, 0);
        line(1, 0, 280, 1440, 0);
        line(0, 0, 268, 1440, 0);
        code(0, 0, 1'b1, 0);
        repeat (12) send(8'h10);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule